// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block is the command-decoding and protection part of a serial flash slave. It watches the chip-select, serial clock and serial data-in pins, and the hardware write-protect pin. All four are brought into the system clock domain, and the serial bus is oversampled. Whole commands are framed between a falling and a rising chip select. A command acts only when chip select rises at its end. The block recognises two arming opcodes and the write-status opcode. It holds the block-protect and lock bits that the write-status command updates.

A status write is a two-step sequence. First comes an arming frame, 0x50 or 0x06. Next comes, as the very next command, a 16-clock frame: opcode 0x01 followed by one data byte. The lock bit and the write-protect pin together decide whether the new byte lands in full, lands with the lock bit only able to rise, or is ignored.

The control state machine has six states. IDLE moves to OPCODE on a chip-select fall. OPCODE moves, on its first complete byte, to one of three states. It goes to ARM_END for an arming opcode and to DATA for the write opcode. It goes to OTHER for anything else. ARM_END and WRITE_END move to OTHER if another byte arrives. DATA moves to WRITE_END on the data byte. From every state, a chip-select rise returns to IDLE. On that rise the state machine issues one action. An odd bit count means discard. ARM_END means arm. WRITE_END means commit. DATA or OTHER means cancel. IDLE or OPCODE with no bits means no action.

Top module: `sflash_sr_guard`

## Requirements
- R1: A complete 8-bit frame with opcode 0x50 or 0x06 sets `wsr_armed_o` after chip select rises. Opcode 0x06 also sets the write-enable latch, status bit 1.
- R2: A frame of opcode 0x01 followed by one data byte, shifted most-significant bit first, changes the status register only when the block was armed at the moment chip select rose.
- R3: Any other complete frame clears the arming flag and the write-enable latch. This includes an unknown opcode, and an arming or write opcode with the wrong byte count. Such a frame changes no protect bit.
- R4: Every completed write-status frame clears the arming flag and the write-enable latch, whether or not its data was applied.
- R5: Nothing changes before chip select rises. A frame whose bit count is not a multiple of 8 is discarded and leaves the arming flag as it was.
- R6: Data bits 5..2 go to the block-protect bits at status bits 5..2. Data bit 7 goes to the lock bit at status bit 7. Data bits 6, 1 and 0 are ignored, and status bits 0 and 6 read 0.
- R7: With the protect pin low and the lock bit at 1, a write-status command leaves the status register unchanged.
- R8: With the protect pin low and the lock bit at 0, a write may set the lock bit and the protect bits together. After that, the lock bit cannot return to 0 while the pin stays low.
- R9: With the protect pin high, all five writable bits take the data byte, including clearing the lock bit.
- R10: Serial data is sampled on rising clock edges in both mode 0 (clock idles low) and mode 3 (clock idles high).
- R11: The serial-out enable `so_oe_o` stays 0 throughout.
- R12: After reset, the status register reads 0x00 and the arming flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Hardware write protect, active low |
| status_o | output | 8 | Status register contents |
| wsr_armed_o | output | 1 | Status write armed |
| so_oe_o | output | 1 | Serial-out drive enable, always 0 here |

## Verification
A wrong state in the command machine appears as a wrong `wsr_armed_o` or `status_o` a few system clocks after the chip-select rise that ends the frame. An armed flag that survives an intervening command shows up on the next write frame as protect bits that should not have moved. A broken lock rule shows at the first frame issued with the protect pin low, as a lock bit that falls or a frozen byte that changes. A bit-counter slip shows at once: a partial frame that should be discarded either arms the block or drops an existing arm.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
    localparam int BYTE_W = 8;
    localparam int PH_W   = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OP_ARM_SR  = 8'h50;
    localparam logic [BYTE_W-1:0] OP_ARM_WEL = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WR_SR   = 8'h01;

    // status bit positions
    localparam int SB_BUSY = 0;
    localparam int SB_WEL  = 1;
    localparam int SB_BP_LO = 2;
    localparam int SB_BP_HI = 5;
    localparam int SB_RSV  = 6;
    localparam int SB_LOCK = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ARM_END,
        ST_DATA,
        ST_WRITE_END,
        ST_OTHER
    } cmd_state_e;

    typedef struct packed {
        logic arm;
        logic arm_wel;
        logic commit;
        logic cancel;
    } cmd_act_t;
endpackage

// File: rtl/sfsr_pin_sync.sv
module sfsr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic cs_low,
    output logic cs_rise,
    output logic cs_fall,
    output logic sck_rise,
    output logic si_s,
    output logic wp_n_s
);
    localparam int NPIN = 4;
    localparam logic [NPIN-1:0] RST_VAL = 4'b1001; // wp_n, si, sck, cs_n

    logic [NPIN-1:0] pins;
    logic [NPIN-1:0] synced;
    logic            cs_d;
    logic            sck_d;

    assign pins = {wp_n, si, sck, cs_n};

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[p]}};
            end else begin
                chain <= {chain[STAGES-2:0], pins[p]};
            end
        end
        assign synced[p] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= synced[0];
            sck_d <= synced[1];
        end
    end

    assign cs_low   = ~synced[0];
    assign cs_rise  = synced[0] & ~cs_d;
    assign cs_fall  = ~synced[0] & cs_d;
    assign sck_rise = synced[1] & ~sck_d & ~synced[0];
    assign si_s     = synced[2];
    assign wp_n_s   = synced[3];
endmodule

// File: rtl/sfsr_shifter.sv
module sfsr_shifter
    import sfsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              din,
    output logic [BYTE_W-1:0] byte_q,
    output logic              byte_stb,
    output logic [PH_W-1:0]   phase
);
    logic [BYTE_W-2:0] sr;
    logic [BYTE_W-1:0] next_byte;

    assign next_byte = {sr, din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr       <= '0;
            phase    <= '0;
            byte_q   <= '0;
            byte_stb <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (clear) begin
                sr    <= '0;
                phase <= '0;
            end else if (shift_en) begin
                sr    <= next_byte[BYTE_W-2:0];
                phase <= phase + 1'b1;
                if (phase == PH_W'(BYTE_W - 1)) begin
                    byte_q   <= next_byte;
                    byte_stb <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sfsr_cmd_fsm.sv
module sfsr_cmd_fsm
    import sfsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_q,
    input  logic [PH_W-1:0]   phase,
    output cmd_act_t          act
);
    cmd_state_e state, state_nx;
    logic       aligned;

    assign aligned = (phase == '0);

    always_comb begin
        state_nx = state;
        if (cs_rise) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cs_fall) state_nx = ST_OPCODE;
                end
                ST_OPCODE: begin
                    if (byte_stb) begin
                        if (byte_q == OP_ARM_SR || byte_q == OP_ARM_WEL)
                            state_nx = ST_ARM_END;
                        else if (byte_q == OP_WR_SR)
                            state_nx = ST_DATA;
                        else
                            state_nx = ST_OTHER;
                    end
                end
                ST_ARM_END: begin
                    if (byte_stb) state_nx = ST_OTHER;
                end
                ST_DATA: begin
                    if (byte_stb) state_nx = ST_WRITE_END;
                end
                ST_WRITE_END: begin
                    if (byte_stb) state_nx = ST_OTHER;
                end
                ST_OTHER: begin
                    state_nx = ST_OTHER;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // arming opcode remembered for the WEL variant
    logic arm_is_wel;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_is_wel <= 1'b0;
        end else if (state == ST_OPCODE && byte_stb) begin
            arm_is_wel <= (byte_q == OP_ARM_WEL);
        end
    end

    always_comb begin
        act = '0;
        if (cs_rise && aligned) begin
            unique case (state)
                ST_IDLE, ST_OPCODE: act = '0;
                ST_ARM_END: begin
                    act.arm     = 1'b1;
                    act.arm_wel = arm_is_wel;
                end
                ST_WRITE_END: act.commit = 1'b1;
                ST_DATA, ST_OTHER: act.cancel = 1'b1;
                default: act = '0;
            endcase
        end
    end
endmodule

// File: rtl/sfsr_status_reg.sv
module sfsr_status_reg
    import sfsr_pkg::*;
#(
    parameter int BP_W = SB_BP_HI - SB_BP_LO + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_act_t          act,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wp_n_s,
    output logic [BYTE_W-1:0] status,
    output logic              armed
);
    logic [BP_W-1:0] bp;
    logic            lock;
    logic            wel;
    logic            frozen;

    assign frozen = lock & ~wp_n_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp    <= '0;
            lock  <= 1'b0;
            wel   <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (act.arm) begin
                armed <= 1'b1;
                if (act.arm_wel) wel <= 1'b1;
            end else if (act.commit) begin
                armed <= 1'b0;
                wel   <= 1'b0;
                if (armed && !frozen) begin
                    bp   <= wdata[SB_BP_HI:SB_BP_LO];
                    lock <= wdata[SB_LOCK];
                end
            end else if (act.cancel) begin
                armed <= 1'b0;
                wel   <= 1'b0;
            end
        end
    end

    always_comb begin
        status                   = '0;
        status[SB_BUSY]          = 1'b0;
        status[SB_WEL]           = wel;
        status[SB_BP_HI:SB_BP_LO] = bp;
        status[SB_RSV]           = 1'b0;
        status[SB_LOCK]          = lock;
    end
endmodule

// File: rtl/sflash_sr_guard.sv
module sflash_sr_guard
    import sfsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sck,
    input  logic        si,
    input  logic        wp_n,
    output logic [7:0]  status_o,
    output logic        wsr_armed_o,
    output logic        so_oe_o
);
    logic              cs_low_s;
    logic              cs_rise_s;
    logic              cs_fall_s;
    logic              sck_rise_s;
    logic              si_s;
    logic              wp_s;
    logic [BYTE_W-1:0] byte_q;
    logic              byte_stb;
    logic [PH_W-1:0]   phase;
    cmd_act_t          act;

    sfsr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .si       (si),
        .wp_n     (wp_n),
        .cs_low   (cs_low_s),
        .cs_rise  (cs_rise_s),
        .cs_fall  (cs_fall_s),
        .sck_rise (sck_rise_s),
        .si_s     (si_s),
        .wp_n_s   (wp_s)
    );

    sfsr_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cs_fall_s),
        .shift_en (sck_rise_s & cs_low_s),
        .din      (si_s),
        .byte_q   (byte_q),
        .byte_stb (byte_stb),
        .phase    (phase)
    );

    sfsr_cmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_fall  (cs_fall_s),
        .cs_rise  (cs_rise_s),
        .byte_stb (byte_stb),
        .byte_q   (byte_q),
        .phase    (phase),
        .act      (act)
    );

    sfsr_status_reg u_sreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .wdata  (byte_q),
        .wp_n_s (wp_s),
        .status (status_o),
        .armed  (wsr_armed_o)
    );

    assign so_oe_o = 1'b0;
endmodule

// File: rtl/sflash_sr_guard_chk.sv
module sflash_sr_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status_o,
    input logic       wsr_armed_o,
    input logic       cs_rise_s,
    input logic       wp_s
);
    // R5
    status_only_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise_s |=> $stable(status_o));

    // R7
    frozen_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] && !wp_s) |=> $stable(status_o[7:2]));

    // R8
    lock_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] && !wp_s) |=> status_o[7]);

    // R2
    write_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_o[7:2]) |-> $past(wsr_armed_o));

    // R4
    arm_drop_on_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wsr_armed_o) |-> $past(cs_rise_s));
endmodule

bind sflash_sr_guard sflash_sr_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_o    (status_o),
    .wsr_armed_o (wsr_armed_o),
    .cs_rise_s   (cs_rise_s),
    .wp_s        (wp_s)
);

// File: tb/sflash_sr_guard_tb.sv
module sflash_sr_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       wp_n = 1'b1;
    logic [7:0] status_o;
    logic       wsr_armed_o;
    logic       so_oe_o;

    int n_vec = 0;
    int n_bad = 0;
    bit so_seen = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] st;
        logic       arm;
        string      tag;
    } exp_t;
    exp_t q[$];
    event chk_ev;

    // reference model state
    logic [3:0] m_bp = '0;
    logic       m_lock = 1'b0;
    logic       m_wel = 1'b0;
    logic       m_arm = 1'b0;

    always #5 clk = ~clk;

    sflash_sr_guard u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
        .status_o(status_o), .wsr_armed_o(wsr_armed_o), .so_oe_o(so_oe_o)
    );

    always @(negedge clk) if (so_oe_o) so_seen = 1'b1;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void model(input logic [23:0] bits, input int nbits);
        logic [7:0] op;
        logic [7:0] d;
        int nb;
        op = bits[23:16];
        d  = bits[15:8];
        nb = nbits / 8;
        if ((nbits % 8) != 0 || nb == 0) return;
        if (nb == 1 && (op == 8'h50 || op == 8'h06)) begin
            m_arm = 1'b1;
            if (op == 8'h06) m_wel = 1'b1;
        end else if (nb == 2 && op == 8'h01) begin
            if (m_arm && !(m_lock && !wp_n)) begin
                m_bp   = d[5:2];
                m_lock = d[7];
            end
            m_arm = 1'b0;
            m_wel = 1'b0;
        end else begin
            m_arm = 1'b0;
            m_wel = 1'b0;
        end
    endfunction

    task automatic send(input logic [23:0] bits, input int nbits,
                        input bit mode3, input string tag);
        exp_t e;
        sck = mode3;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0;
            si  = bits[23-i];
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
        end
        if (!mode3) sck = 1'b0;
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(12);
        model(bits, nbits);
        e.st  = {m_lock, 1'b0, m_bp, m_wel, 1'b0};
        e.arm = m_arm;
        e.tag = tag;
        q.push_back(e);
        -> chk_ev;
        wait_clk(2);
    endtask

    // monitor / scoreboard
    initial begin
        exp_t e;
        forever begin
            @(chk_ev);
            e = q.pop_front();
            n_vec++;
            if (status_o !== e.st || wsr_armed_o !== e.arm) begin
                n_bad++;
                $display("FAIL %s: status=%02h armed=%0b expected status=%02h armed=%0b",
                         e.tag, status_o, wsr_armed_o, e.st, e.arm);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(6);
        // R12 reset state
        n_vec++;
        if (status_o !== 8'h00 || wsr_armed_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R12: status=%02h armed=%0b expected status=00 armed=0",
                     status_o, wsr_armed_o);
        end

        send(24'h01_BC_00, 16, 1'b0, "R2 write without arm");
        send(24'h50_00_00,  8, 1'b0, "R1 arm 0x50");
        send(24'h01_3C_00, 16, 1'b0, "R6 write bp=1111");
        send(24'h06_00_00,  8, 1'b0, "R1 arm 0x06 sets WEL");
        send(24'h03_12_34, 24, 1'b0, "R3 other opcode cancels");
        send(24'h01_00_00, 16, 1'b0, "R3 write after cancel ignored");
        send(24'h50_00_00,  8, 1'b1, "R10 arm mode 3");
        send(24'h01_F0_00, 12, 1'b1, "R5 partial frame discarded");
        send(24'h01_D7_00, 16, 1'b1, "R9 R6 mode 3 lock plus bp, ignored bits");
        send(24'h01_00_00, 16, 1'b0, "R4 second write unarmed");
        wp_n = 1'b0;
        wait_clk(8);
        send(24'h50_00_00,  8, 1'b0, "R7 arm while locked");
        send(24'h01_00_00, 16, 1'b0, "R7 locked write ignored");
        send(24'h01_00_00, 16, 1'b0, "R4 arm cleared after ignored write");
        wp_n = 1'b1;
        wait_clk(8);
        send(24'h50_00_00,  8, 1'b0, "R9 arm pin high");
        send(24'h01_00_00, 16, 1'b0, "R9 lock cleared pin high");
        wp_n = 1'b0;
        wait_clk(8);
        send(24'h06_00_00,  8, 1'b1, "R8 arm pin low unlocked");
        send(24'h01_88_00, 16, 1'b1, "R8 set lock pin low");
        send(24'h50_00_00,  8, 1'b0, "R8 arm again");
        send(24'h01_00_00, 16, 1'b0, "R8 lock holds pin low");
        wp_n = 1'b1;
        wait_clk(8);
        send(24'h50_00_00,  8, 1'b0, "R9 arm pin high");
        send(24'h01_08_00, 16, 1'b0, "R9 unlock write");
        send(24'h50_00_00,  8, 1'b0, "R3 arm before long write");
        send(24'h01_FC_FF, 24, 1'b0, "R3 three-byte write cancels");
        send(24'h06_00_00,  8, 1'b0, "R3 arm before long arm");
        send(24'h50_00_00, 16, 1'b0, "R3 two-byte arm opcode cancels");
        send(24'h50_00_00, 10, 1'b0, "R5 partial arm discarded");

        n_vec++;
        if (so_seen !== 1'b0) begin
            n_bad++;
            $display("FAIL R11: so_oe seen=%0b expected=0", so_seen);
        end

        wait_clk(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule